// File: doc/BRIEF.md
# Memory-Controller Event Counter Set

This block sits beside a DRAM controller and tallies the performance strobes the controller exports. It holds a bank of equal-width counters. Counter 0 is a free-running time base. Each of the other counters picks its event through a private configuration register. The event can be a single strobe line, a filtered read beat or a filtered write beat. Filtered beats pass only when their transaction ID agrees with a programmed value on the bit positions that a mask enables. One register holds that value and mask, and every counter uses it.

Software arms the set by writing the run bit and then lets it count. When the time base rolls over from all-ones to zero, the whole set freezes in that same edge and the interrupt goes high. The interrupt stays high until software writes the control register again. The event counters wrap without any notice. A per-counter byte option makes a filtered counter add the beat's byte count, two to the power of the size code, in place of one.

Top module: `memctl_evt_counters`

## Requirements
- R1: After reset every counter reads zero and the interrupt is low. Nothing counts while the run bit (control register bit 0) is clear.
- R2: While running and not frozen, counter 0 adds exactly one per clock cycle, whatever the inputs are.
- R3: A config code below EVT_W (config bits [7:0]) makes that counter add one in each cycle where strobe bit `evt_i[code]` is high.
- R4: Code 0x41 counts cycles with `txn_valid_i` high and `txn_wr_i` low that pass the filter. Code 0x42 counts the same with `txn_wr_i` high.
- R5: A beat passes the filter when (`txn_id_i` AND mask) equals (programmed ID AND mask). A mask bit of 1 takes part in the compare and a mask bit of 0 is ignored.
- R6: One filter register, at address NUM_CNT, holds the ID in bits [ID_W-1:0] and the mask in bits [2*ID_W-1:ID_W]. Every counter that uses code 0x41 or 0x42 uses this one value.
- R7: With config bit 8 set, a 0x41/0x42 counter adds 2^`txn_size_i` per passing beat. Strobe codes still add one.
- R8: When counter 0 wraps from all-ones to zero, the freeze and the interrupt are set at that same edge. No counter changes while frozen.
- R9: Counters 1 and above wrap modulo 2^CNT_W and never raise the interrupt.
- R10: Any write to the control register clears the freeze and the interrupt, and counting resumes from the next cycle. If counter 0 wraps in the cycle of that write, the freeze is set.
- R11: A code that is neither below EVT_W nor 0x41/0x42 never increments its counter. Reset loads code 0xFF.
- R12: The register map is: address 0 is control, addresses 1 to NUM_CNT-1 are the configs of counters 1 to NUM_CNT-1, and address NUM_CNT is the filter. A write occurs in a cycle with `reg_wr_i` high and takes effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | EVT_W | Performance strobes from the controller |
| txn_valid_i | input | 1 | A data beat is present this cycle |
| txn_wr_i | input | 1 | Beat is a write (1) or a read (0) |
| txn_id_i | input | ID_W | Transaction ID of the beat |
| txn_size_i | input | 3 | Beat size code, bytes = 2^code |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | REG_W | Register write data |
| cnt_o | output | NUM_CNT*CNT_W | Counter values, counter k in bits [k*CNT_W +: CNT_W] |
| irq_o | output | 1 | Time-base expiry interrupt |

## Verification
Every counter is visible at the ports in every cycle, so a wrong increment, a wrong filter decision or a wrong byte amount shows as a miscompare one cycle after the beat that caused it. A freeze that is missing, late or stuck shows either as a counter that moves after counter 0 rolls over or as one that stops while the interrupt is low. Both are seen within one cycle. A wrong priority between clearing and a new expiry shows only in the single cycle where the two coincide, so the bench steers a control write onto that exact cycle.

// File: rtl/memctl_cnt_pkg.sv
package memctl_cnt_pkg;

  // Event codes that use the shared transaction-ID filter
  localparam logic [7:0] CODE_RD_FLT = 8'h41;
  localparam logic [7:0] CODE_WR_FLT = 8'h42;
  localparam logic [7:0] CODE_NONE   = 8'hFF;

  // Width of a single increment: largest beat is 2^7 = 128 bytes
  localparam int unsigned BEAT_W = 8;

  typedef struct packed {
    logic       bytes;  // add beat bytes instead of one
    logic [7:0] code;   // event select
  } cnt_cfg_t;

  // Masked compare: mask bit 1 means the bit is compared
  function automatic logic id_pass(input logic [31:0] id,
                                   input logic [31:0] match,
                                   input logic [31:0] mask);
    return (id & mask) == (match & mask);
  endfunction

  // Bytes carried by one beat of the given size code
  function automatic logic [BEAT_W-1:0] beat_bytes(input logic [2:0] size);
    return BEAT_W'(1) << size;
  endfunction

endpackage

// File: rtl/memctl_evt_sel.sv
module memctl_evt_sel
  import memctl_cnt_pkg::*;
#(
  parameter int unsigned EVT_W = 16,
  parameter int unsigned ID_W  = 16
) (
  input  cnt_cfg_t          cfg,
  input  logic [EVT_W-1:0]  evt,
  input  logic              txn_valid,
  input  logic              txn_wr,
  input  logic [ID_W-1:0]   txn_id,
  input  logic [2:0]        txn_size,
  input  logic [ID_W-1:0]   flt_id,
  input  logic [ID_W-1:0]   flt_mask,
  output logic [BEAT_W-1:0] inc
);
  localparam int unsigned SEL_W = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  logic is_strobe, dir_hit, flt_hit;

  assign is_strobe = cfg.code < 8'(EVT_W);
  assign dir_hit   = (cfg.code == CODE_RD_FLT && !txn_wr) ||
                     (cfg.code == CODE_WR_FLT &&  txn_wr);
  assign flt_hit   = txn_valid && dir_hit &&
                     id_pass(32'(txn_id), 32'(flt_id), 32'(flt_mask));

  always_comb begin
    inc = '0;
    if (is_strobe) begin
      inc = BEAT_W'(evt[cfg.code[SEL_W-1:0]]);
    end else if (flt_hit) begin
      inc = cfg.bytes ? beat_bytes(txn_size) : BEAT_W'(1);
    end
  end

endmodule

// File: rtl/memctl_cnt_reg.sv
module memctl_cnt_reg
  import memctl_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BEAT_W-1:0] inc,
  output logic [CNT_W-1:0]  value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (en) begin
      value <= value + CNT_W'(inc);  // wraps modulo 2^CNT_W
    end
  end
endmodule

// File: rtl/memctl_evt_counters.sv
module memctl_evt_counters
  import memctl_cnt_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned EVT_W   = 16,
  parameter int unsigned ID_W    = 16,
  parameter int unsigned REG_W   = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [EVT_W-1:0]         evt_i,
  input  logic                     txn_valid_i,
  input  logic                     txn_wr_i,
  input  logic [ID_W-1:0]          txn_id_i,
  input  logic [2:0]               txn_size_i,
  input  logic                     reg_wr_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [REG_W-1:0]         reg_wdata_i,
  output logic [NUM_CNT*CNT_W-1:0] cnt_o,
  output logic                     irq_o
);
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_FLT  = NUM_CNT;
  localparam int unsigned CFG_W     = $bits(cnt_cfg_t);

  logic            run_q, lock_q;
  cnt_cfg_t        cfg_q [1:NUM_CNT-1];
  logic [ID_W-1:0] flt_id_q, flt_mask_q;

  // Named internal events used by the checker
  logic ctrl_wr, flt_wr, count_en, wrap0;
  logic [CNT_W-1:0]  cnt_val [NUM_CNT];
  logic [BEAT_W-1:0] inc_amt [NUM_CNT];

  assign ctrl_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CTRL));
  assign flt_wr   = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_FLT));
  assign count_en = run_q && !lock_q;
  assign wrap0    = count_en && (cnt_val[0] == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      lock_q     <= 1'b0;
      flt_id_q   <= '0;
      flt_mask_q <= '0;
      for (int k = 1; k < NUM_CNT; k++) cfg_q[k] <= '{bytes: 1'b0, code: CODE_NONE};
    end else begin
      if (ctrl_wr) run_q <= reg_wdata_i[0];
      // a new expiry outranks a clear in the same cycle
      lock_q <= wrap0 || (lock_q && !ctrl_wr);
      if (flt_wr) begin
        flt_id_q   <= reg_wdata_i[ID_W-1:0];
        flt_mask_q <= reg_wdata_i[2*ID_W-1:ID_W];
      end
      for (int k = 1; k < NUM_CNT; k++) begin
        if (reg_wr_i && reg_addr_i == ADDR_W'(k)) cfg_q[k] <= cnt_cfg_t'(reg_wdata_i[CFG_W-1:0]);
      end
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i == 0) begin : g_time
      assign inc_amt[i] = BEAT_W'(1);
    end else begin : g_evt
      memctl_evt_sel #(.EVT_W(EVT_W), .ID_W(ID_W)) u_sel (
        .cfg      (cfg_q[i]),
        .evt      (evt_i),
        .txn_valid(txn_valid_i),
        .txn_wr   (txn_wr_i),
        .txn_id   (txn_id_i),
        .txn_size (txn_size_i),
        .flt_id   (flt_id_q),
        .flt_mask (flt_mask_q),
        .inc      (inc_amt[i])
      );
    end
    memctl_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (count_en),
      .inc  (inc_amt[i]),
      .value(cnt_val[i])
    );
    assign cnt_o[i*CNT_W +: CNT_W] = cnt_val[i];
  end

  assign irq_o = lock_q;

endmodule

// File: rtl/memctl_evt_counters_chk.sv
module memctl_evt_counters_chk #(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned CNT_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     run_q,
  input logic                     lock_q,
  input logic                     ctrl_wr,
  input logic                     wrap0,
  input logic                     irq_o,
  input logic [NUM_CNT*CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] t0;
  assign t0 = cnt_o[CNT_W-1:0];

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(cnt_o)); // R1

  AST_TIME_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !lock_q && !wrap0) |=> t0 == $past(t0) + CNT_W'(1)); // R2

  AST_WRAP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    wrap0 |=> (t0 == '0) && irq_o); // R8

  AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(cnt_o)); // R8

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(wrap0)); // R9

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wrap0) |=> !irq_o); // R10

endmodule

bind memctl_evt_counters memctl_evt_counters_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .run_q  (run_q),
  .lock_q (lock_q),
  .ctrl_wr(ctrl_wr),
  .wrap0  (wrap0),
  .irq_o  (irq_o),
  .cnt_o  (cnt_o)
);

// File: tb/memctl_evt_counters_tb_top.sv
`timescale 1ns/100ps
module memctl_evt_counters_tb_top;
  localparam int unsigned NC = 4;
  localparam int unsigned CW = 12;   // short counters so wraps fit the run
  localparam int unsigned EW = 16;
  localparam int unsigned IW = 16;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [EW-1:0] evt = '0;
  logic tv = 1'b0, tw = 1'b0;
  logic [IW-1:0] tid = '0;
  logic [2:0] tsz = '0;
  logic rwr = 1'b0;
  logic [3:0] raddr = '0;
  logic [31:0] rdata = '0;
  logic [NC*CW-1:0] cnt;
  logic irq;

  always #2.5 clk = ~clk;

  memctl_evt_counters #(.NUM_CNT(NC), .CNT_W(CW), .EVT_W(EW), .ID_W(IW),
                        .REG_W(32), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .txn_valid_i(tv), .txn_wr_i(tw),
    .txn_id_i(tid), .txn_size_i(tsz), .reg_wr_i(rwr), .reg_addr_i(raddr),
    .reg_wdata_i(rdata), .cnt_o(cnt), .irq_o(irq));

  typedef struct {
    logic [CW-1:0] c [NC];
    logic          irq;
    string         tag [NC];
  } exp_t;

  exp_t q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference state
  logic [CW-1:0] mc [NC];
  logic [7:0] mcode [NC];
  logic mbyte [NC];
  logic mrun = 0, mlock = 0;
  logic [IW-1:0] fid = '0, fmask = '0;
  string cur_tag = "";

  function automatic int unsigned ref_add(int i);
    if (i == 0) return 1;
    if (mcode[i] < 8'(EW)) return int'(evt[mcode[i][3:0]]);
    if (!tv) return 0;
    if (!((mcode[i] == 8'h41 && !tw) || (mcode[i] == 8'h42 && tw))) return 0;
    if (((tid ^ fid) & fmask) != '0) return 0;
    return mbyte[i] ? (32'd1 << tsz) : 1;
  endfunction

  function automatic string ref_tag(int i);
    if (cur_tag != "") return cur_tag;
    if (i == 0) return "R2";
    if (mcode[i] < 8'(EW)) return "R3";
    if (mcode[i] == 8'h41 || mcode[i] == 8'h42) return mbyte[i] ? "R7" : "R4 R5 R6";
    return "R11";
  endfunction

  // Driver: one cycle of stimulus, one expected item
  task automatic step(input logic [EW-1:0] e, input logic v, input logic w,
                      input logic [IW-1:0] id, input logic [2:0] sz,
                      input logic wr, input logic [3:0] a, input logic [31:0] d);
    exp_t it;
    logic en, wrap;
    @(negedge clk);
    evt = e; tv = v; tw = w; tid = id; tsz = sz; rwr = wr; raddr = a; rdata = d;
    en = mrun && !mlock;
    wrap = en && (mc[0] == MAXV);
    for (int i = 0; i < NC; i++) begin
      it.tag[i] = ref_tag(i);
      if (en) mc[i] = CW'(int'(mc[i]) + ref_add(i));
    end
    mlock = wrap || (mlock && !(wr && a == 4'd0));
    if (wr) begin  // R12 map: 0 control, 1..3 configs, 4 filter
      if (a == 4'd0) mrun = d[0];
      else if (a < 4'(NC)) begin mcode[a] = d[7:0]; mbyte[a] = d[8]; end
      else if (a == 4'(NC)) begin fid = d[15:0]; fmask = d[31:16]; end
    end
    for (int i = 0; i < NC; i++) it.c[i] = mc[i];
    it.irq = mlock;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(EW'($urandom), 1'b0, 1'b0, '0, '0, 1'b0, '0, '0);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    step('0, 1'b0, 1'b0, '0, '0, 1'b1, a, d);
  endtask

  task automatic traffic(input int n);
    for (int k = 0; k < n; k++) begin
      logic [IW-1:0] id;
      id = ($urandom_range(0, 1) == 1) ? (16'h0A50 | IW'($urandom & 32'h00F0)) : IW'($urandom);
      step(EW'($urandom), 1'($urandom), 1'($urandom), id, 3'($urandom), 1'b0, '0, '0);
    end
  endtask

  // Monitor: compare one item per cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        vectors++;
        for (int i = 0; i < NC; i++) begin
          if (cnt[i*CW +: CW] !== it.c[i]) begin
            miscompares++;
            $display("FAIL %s cnt%0d actual %0h expected %0h", it.tag[i], i, cnt[i*CW +: CW], it.c[i]);
          end
        end
        if (irq !== it.irq) begin
          miscompares++;
          $display("FAIL %s irq actual %0b expected %0b", (cur_tag != "") ? cur_tag : "R8 R9", irq, it.irq);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin mc[i] = '0; mcode[i] = 8'hFF; mbyte[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    vectors++;
    if (cnt !== '0 || irq !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset actual %0h/%0b expected 0/0", cnt, irq);
    end
    cur_tag = "R1";
    wreg(4'd1, 32'h0000_0003);
    traffic(40);                 // not running: all stay zero
    cur_tag = "";
    // R12 layout, R6 shared filter: id 0x0A50, mask 0xFF0F
    wreg(4'd2, 32'h0000_0041);
    wreg(4'd3, 32'h0000_0042);
    wreg(4'd4, 32'hFF0F_0A50);
    wreg(4'd0, 32'h1);
    traffic(300);
    // R7 byte mode on writes and on a strobe; R11 unlisted code
    wreg(4'd3, 32'h0000_0142);
    wreg(4'd1, 32'h0000_0105);
    wreg(4'd2, 32'h0000_0030);
    traffic(300);
    // R5: all-ones mask, exact id only
    wreg(4'd4, 32'hFFFF_1234);
    wreg(4'd2, 32'h0000_0041);
    for (int k = 0; k < 60; k++)
      step('0, 1'b1, 1'($urandom), (k % 3 == 0) ? 16'h1234 : 16'h1235, 3'd2, 1'b0, '0, '0);
    // R9: event counter wraps quietly
    cur_tag = "R9";
    wreg(4'd4, 32'h0000_0000);
    wreg(4'd1, 32'h0000_0141);
    for (int k = 0; k < 80; k++) step('0, 1'b1, 1'b0, IW'($urandom), 3'd7, 1'b0, '0, '0);
    wreg(4'd1, 32'h0000_0003);
    // R8: run to time-base expiry, then stay frozen
    cur_tag = "R8";
    while (!mlock) step(EW'($urandom), 1'b1, 1'($urandom), IW'($urandom), 3'($urandom), 1'b0, '0, '0);
    traffic(30);
    // R10: control write clears and resumes
    cur_tag = "R10";
    wreg(4'd0, 32'h1);
    traffic(40);
    while (mc[0] != MAXV) idle(1);
    wreg(4'd0, 32'h1);           // coincides with expiry: freeze wins
    idle(5);
    wreg(4'd0, 32'h1);
    idle(10);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule